// File: doc/BRIEF.md
# Rate-selectable receive clock divider

This block takes one fast bit-rate clock and turns it into the enable pulses that a receive path needs at lower line rates. A serial stage slows the bit clock by 1, 2 or 4. Two parallel stages then produce word-rate pulses for an 8-bit data path and a 16-bit data path. Every output is a single-cycle enable on the fast clock, so all downstream logic stays in one clock domain.

The serial ratio comes from two sources. A static setting is captured while reset is held. A 2-bit run-time rate code can then override it. Code `00` hands control back to the captured static value. Any change of ratio waits for the end of the serial period that is running, so no period is ever cut short.

An output selector picks one enable to drive out. The choices are the recovered 8-bit or 16-bit word enable, a pass-through enable from an external oversampling path, or a reference word enable at 8-bit or 16-bit width. The reference enables are taken from the undivided fast clock.

Top module: `rx_rate_clkdiv`

## Requirements
- R1: The serial enable `ser_en_o` pulses exactly once every N fast-clock cycles, where N is the active ratio (1, 2 or 4). `cur_div_o` always reports N as the plain number 1, 2 or 4.
- R2: Rate code `rate_sel_i` = 2'b11 selects ratio 1, 2'b10 selects ratio 2, and 2'b01 selects ratio 4.
- R3: Rate code 2'b00 selects the static ratio that was captured at reset.
- R4: The static input `static_div_i` is sampled only while `rst_i` is high. The values 2 and 4 give those ratios, and every other value gives ratio 1. Changes to it after reset have no effect.
- R5: Synchronous active-high reset clears all counters and makes the captured static ratio the active one. The first `ser_en_o` after reset comes in the Nth cycle after release.
- R6: A new rate code is applied only in the cycle where `ser_en_o` is high, and it sets the length of the next period. The period already running always completes at its old length.
- R7: `rec1_en_o` is high together with every 8th `ser_en_o` pulse counted from reset, and is low at all other times.
- R8: `rec2_en_o` is high together with every 16th `ser_en_o` pulse counted from reset, so it is always high together with `rec1_en_o`.
- R9: The reference 8-bit enable pulses in every 8th fast-clock cycle after reset, and the reference 16-bit enable pulses in every 16th. Neither depends on the serial ratio.
- R10: `sel_en_o` drives one source, chosen by `out_sel_i`: 0 recovered 8-bit, 1 recovered 16-bit, 2 `ovs_en_i`, 3 reference 8-bit, 4 reference 16-bit. Codes 5 to 7 drive 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast bit-rate clock |
| rst_i | input | 1 | Synchronous active-high reset; also captures the static ratio |
| static_div_i | input | 3 | Static ratio captured at reset (1, 2 or 4) |
| rate_sel_i | input | 2 | Run-time rate code |
| out_sel_i | input | 3 | Output source select |
| ovs_en_i | input | 1 | Enable from the oversampling path, passed through |
| ser_en_o | output | 1 | Divided serial enable |
| rec1_en_o | output | 1 | Recovered 8-bit word enable |
| rec2_en_o | output | 1 | Recovered 16-bit word enable |
| sel_en_o | output | 1 | Selected output enable |
| cur_div_o | output | 3 | Active serial ratio |

## Verification
The bench first holds the rate code at `00` and tries each static value, including the illegal values 0, 3 and 7. This separates the captured-value path from the code map, and it shows whether illegal settings fall back to ratio 1. Next, each non-zero rate code runs against a static value that differs from it, which shows that the override takes priority. A random phase changes the rate code at arbitrary cycles and sweeps all eight selector codes. It measures every serial period against the code that was present at the end of the previous period, and this exposes any change that is applied early or that cuts a period short. A separate run alters the static input after reset to show that the input is ignored once reset is released.

// File: rtl/rcd_pkg.sv
package rcd_pkg;

    // Run-time rate codes; 00 defers to the value captured at reset.
    typedef enum logic [1:0] {
        RATE_STATIC = 2'b00,
        RATE_DIV4   = 2'b01,
        RATE_DIV2   = 2'b10,
        RATE_DIV1   = 2'b11
    } rate_code_e;

    // Serial ratio kept as its base-2 logarithm.
    typedef enum logic [1:0] {
        DIV_BY1 = 2'd0,
        DIV_BY2 = 2'd1,
        DIV_BY4 = 2'd2
    } div_e;

    localparam int unsigned SER_CNT_W = 2;

    localparam logic [2:0] OSEL_REC1 = 3'd0;
    localparam logic [2:0] OSEL_REC2 = 3'd1;
    localparam logic [2:0] OSEL_OVS  = 3'd2;
    localparam logic [2:0] OSEL_REF1 = 3'd3;
    localparam logic [2:0] OSEL_REF2 = 3'd4;

    // All enables that the output selector can choose from.
    typedef struct packed {
        logic rec1;
        logic rec2;
        logic ovs;
        logic ref1;
        logic ref2;
    } clk_en_s;

    function automatic div_e sanitize_static(input logic [2:0] v);
        case (v)
            3'd2:    return DIV_BY2;
            3'd4:    return DIV_BY4;
            default: return DIV_BY1;
        endcase
    endfunction

    function automatic div_e decode_rate(input logic [1:0] code, input div_e stat);
        case (code)
            RATE_DIV1: return DIV_BY1;
            RATE_DIV2: return DIV_BY2;
            RATE_DIV4: return DIV_BY4;
            default:   return stat;
        endcase
    endfunction

    function automatic logic [SER_CNT_W-1:0] last_count(input div_e d);
        case (d)
            DIV_BY2: return 2'd1;
            DIV_BY4: return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic [2:0] div_ratio(input div_e d);
        case (d)
            DIV_BY2: return 3'd2;
            DIV_BY4: return 3'd4;
            default: return 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/rcd_ratio_ctrl.sv
module rcd_ratio_ctrl
    import rcd_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic [2:0] static_div_i,
    input  logic [1:0] rate_sel_i,
    output logic       ser_en_o,
    output div_e       div_o
);

    div_e                 stat_q;
    div_e                 act_q;
    logic [SER_CNT_W-1:0] cnt_q;
    logic                 term_w;

    assign term_w   = (cnt_q == last_count(act_q));
    assign ser_en_o = term_w;
    assign div_o    = act_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stat_q <= sanitize_static(static_div_i);
            act_q  <= sanitize_static(static_div_i);
            cnt_q  <= '0;
        end else if (term_w) begin
            // Ratio switches only at the end of a period.
            cnt_q <= '0;
            act_q <= decode_rate(rate_sel_i, stat_q);
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/rcd_par_gen.sv
module rcd_par_gen #(
    parameter int unsigned BYTE_BITS = 8
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic step_i,
    output logic one_o,
    output logic two_o
);

    localparam int unsigned BYTE_LOG = $clog2(BYTE_BITS);
    localparam int unsigned CNT_W    = BYTE_LOG + 1;

    logic [CNT_W-1:0] cnt_q;

    assign one_o = step_i && (&cnt_q[BYTE_LOG-1:0]);
    assign two_o = step_i && (&cnt_q);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (step_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/rcd_clk_mux.sv
module rcd_clk_mux
    import rcd_pkg::*;
(
    input  logic [2:0] sel_i,
    input  clk_en_s    src_i,
    output logic       en_o
);

    always_comb begin
        case (sel_i)
            OSEL_REC1: en_o = src_i.rec1;
            OSEL_REC2: en_o = src_i.rec2;
            OSEL_OVS:  en_o = src_i.ovs;
            OSEL_REF1: en_o = src_i.ref1;
            OSEL_REF2: en_o = src_i.ref2;
            default:   en_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/rx_rate_clkdiv.sv
module rx_rate_clkdiv
    import rcd_pkg::*;
#(
    parameter int unsigned BYTE_BITS = 8
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic [2:0] static_div_i,
    input  logic [1:0] rate_sel_i,
    input  logic [2:0] out_sel_i,
    input  logic       ovs_en_i,
    output logic       ser_en_o,
    output logic       rec1_en_o,
    output logic       rec2_en_o,
    output logic       sel_en_o,
    output logic [2:0] cur_div_o
);

    localparam int unsigned N_PATHS = 2;  // 0: recovered, 1: reference

    div_e               div_w;
    logic               ser_en_w;
    logic [N_PATHS-1:0] step_w;
    logic [N_PATHS-1:0] one_w;
    logic [N_PATHS-1:0] two_w;
    clk_en_s            src_w;

    rcd_ratio_ctrl u_ratio (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .static_div_i(static_div_i),
        .rate_sel_i  (rate_sel_i),
        .ser_en_o    (ser_en_w),
        .div_o       (div_w)
    );

    assign step_w[0] = ser_en_w;
    assign step_w[1] = 1'b1;

    for (genvar g = 0; g < N_PATHS; g++) begin : g_par
        rcd_par_gen #(.BYTE_BITS(BYTE_BITS)) u_par (
            .clk_i (clk_i),
            .rst_i (rst_i),
            .step_i(step_w[g]),
            .one_o (one_w[g]),
            .two_o (two_w[g])
        );
    end

    assign src_w.rec1 = one_w[0];
    assign src_w.rec2 = two_w[0];
    assign src_w.ovs  = ovs_en_i;
    assign src_w.ref1 = one_w[1];
    assign src_w.ref2 = two_w[1];

    rcd_clk_mux u_mux (
        .sel_i(out_sel_i),
        .src_i(src_w),
        .en_o (sel_en_o)
    );

    assign ser_en_o  = ser_en_w;
    assign rec1_en_o = src_w.rec1;
    assign rec2_en_o = src_w.rec2;
    assign cur_div_o = div_ratio(div_w);

endmodule

// File: rtl/rx_rate_clkdiv_checker.sv
module rx_rate_clkdiv_checker (
    input logic       clk_i,
    input logic       rst_i,
    input logic [1:0] rate_sel_i,
    input logic [2:0] out_sel_i,
    input logic       ser_en_o,
    input logic       rec1_en_o,
    input logic       rec2_en_o,
    input logic       sel_en_o,
    input logic [2:0] cur_div_o
);

    logic [2:0] gap_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || ser_en_o) gap_q <= '0;
        else if (gap_q != 3'd7) gap_q <= gap_q + 3'd1;
    end

    a_r1_period_len: assert property (@(posedge clk_i) disable iff (rst_i)
        ser_en_o |-> (gap_q == 3'(cur_div_o - 3'd1)));

    a_r1_legal_ratio: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones(cur_div_o) == 1 && cur_div_o != 3'd0);

    a_r2_code_fast: assert property (@(posedge clk_i) disable iff (rst_i)
        (ser_en_o && rate_sel_i == 2'b11) |=> (cur_div_o == 3'd1));

    a_r2_code_slow: assert property (@(posedge clk_i) disable iff (rst_i)
        (ser_en_o && rate_sel_i == 2'b01) |=> (cur_div_o == 3'd4));

    a_r6_hold_midperiod: assert property (@(posedge clk_i) disable iff (rst_i)
        !ser_en_o |=> $stable(cur_div_o));

    a_r7_word_on_serial: assert property (@(posedge clk_i) disable iff (rst_i)
        rec1_en_o |-> ser_en_o);

    a_r8_wide_on_narrow: assert property (@(posedge clk_i) disable iff (rst_i)
        rec2_en_o |-> rec1_en_o);

    a_r10_unused_codes: assert property (@(posedge clk_i) disable iff (rst_i)
        (out_sel_i > 3'd4) |-> !sel_en_o);

endmodule

bind rx_rate_clkdiv rx_rate_clkdiv_checker u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .rate_sel_i(rate_sel_i),
    .out_sel_i (out_sel_i),
    .ser_en_o  (ser_en_o),
    .rec1_en_o (rec1_en_o),
    .rec2_en_o (rec2_en_o),
    .sel_en_o  (sel_en_o),
    .cur_div_o (cur_div_o)
);

// File: tb/rx_rate_clkdiv_tb_top.sv
`timescale 1ns/1ps
module rx_rate_clkdiv_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] static_div = 3'd1;
    logic [1:0] rate_sel = 2'b00;
    logic [2:0] out_sel = 3'd0;
    logic       ovs_en = 1'b0;
    logic       ser_en, rec1_en, rec2_en, sel_en;
    logic [2:0] cur_div;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rx_rate_clkdiv dut_i (
        .clk_i       (clk),
        .rst_i       (rst),
        .static_div_i(static_div),
        .rate_sel_i  (rate_sel),
        .out_sel_i   (out_sel),
        .ovs_en_i    (ovs_en),
        .ser_en_o    (ser_en),
        .rec1_en_o   (rec1_en),
        .rec2_en_o   (rec2_en),
        .sel_en_o    (sel_en),
        .cur_div_o   (cur_div)
    );

    function automatic int static_ratio(input logic [2:0] v);
        if (v == 3'd2) return 2;
        if (v == 3'd4) return 4;
        return 1;
    endfunction

    function automatic int next_ratio(input logic [1:0] code, input int stat);
        case (code)
            2'b11:   return 1;
            2'b10:   return 2;
            2'b01:   return 4;
            default: return stat;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
        end
    endtask

    // Reference monitor, sampled on the falling edge.
    int gap, exp_ratio, stat_ref, npulse, cyc;
    always @(negedge clk) begin
        if (rst) begin
            gap = 0; npulse = 0; cyc = 0;
            stat_ref  = static_ratio(static_div);
            exp_ratio = stat_ref;
        end else begin
            bit r1, r2, f1, f2, es;
            cyc++; gap++;
            r1 = 0; r2 = 0;
            f1 = (cyc % 8 == 0);
            f2 = (cyc % 16 == 0);
            if (ser_en) begin
                chk(gap == exp_ratio, "R1 R6 serial period", gap, exp_ratio);
                chk(int'(cur_div) == exp_ratio, "R2 R3 active ratio", cur_div, exp_ratio);
                npulse++;
                r1 = (npulse % 8 == 0);
                r2 = (npulse % 16 == 0);
                chk(rec1_en == r1, "R7 byte enable", rec1_en, r1);
                chk(rec2_en == r2, "R8 word enable", rec2_en, r2);
                exp_ratio = next_ratio(rate_sel, stat_ref);
                gap = 0;
            end else begin
                if (gap >= exp_ratio)
                    chk(1'b0, "R6 missing serial pulse", gap, exp_ratio);
                if (rec1_en || rec2_en)
                    chk(1'b0, "R7 word enable without serial", int'({rec2_en, rec1_en}), 0);
            end
            case (out_sel)
                3'd0: es = r1;
                3'd1: es = r2;
                3'd2: es = ovs_en;
                3'd3: es = f1;
                3'd4: es = f2;
                default: es = 1'b0;
            endcase
            if (out_sel == 3'd3 || out_sel == 3'd4)
                chk(sel_en == es, "R9 reference enable", sel_en, es);
            else
                chk(sel_en == es, "R10 output select", sel_en, es);
        end
    end

    task automatic do_reset(input logic [2:0] st, input logic [1:0] rc);
        @(posedge clk); #1;
        rst = 1'b1; static_div = st; rate_sel = rc;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #1;
        chk(int'(cur_div) == static_ratio(st), "R5 R4 ratio after reset", cur_div, static_ratio(st));
    endtask

    task automatic run(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        logic [2:0] stv [6] = '{3'd1, 3'd2, 3'd4, 3'd3, 3'd0, 3'd7};
        void'($urandom(32'h5EED_C10C));
        // R3 / R4: fallback code with each static value, legal and illegal
        foreach (stv[i]) begin
            do_reset(stv[i], 2'b00);
            run(70);
        end
        // R2: explicit codes override a differing static value
        do_reset(3'd4, 2'b11); run(70);
        do_reset(3'd1, 2'b10); run(70);
        do_reset(3'd2, 2'b01); run(140);
        // R4: static input ignored after reset
        do_reset(3'd4, 2'b00);
        #1 static_div = 3'd2;
        run(100);
        @(negedge clk); #1;
        chk(cur_div == 3'd4, "R4 static ignored after reset", cur_div, 4);
        // R6 directed: request change mid-period of a divide-by-4
        do_reset(3'd4, 2'b00);
        run(1); #1 rate_sel = 2'b11;
        run(40); #1 rate_sel = 2'b01;
        run(40);
        // R9 R10: sweep every selector code
        for (int s = 0; s < 8; s++) begin
            #1 out_sel = 3'(s);
            run(40);
        end
        // Random phase
        for (int k = 0; k < 4; k++) begin
            do_reset(3'($urandom_range(0, 7)), 2'b00);
            for (int c = 0; c < 3000; c++) begin
                @(posedge clk); #1;
                if ($urandom_range(0, 19) == 0) rate_sel = 2'($urandom_range(0, 3));
                out_sel = 3'($urandom_range(0, 7));
                ovs_en  = 1'($urandom_range(0, 1));
            end
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual 0 expected 1 (run completion)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule